// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by an amount read from the low byte of a second register operand. It offers four shift kinds: logical left, logical right, arithmetic right and rotate right. Each accepted request produces the shifted value, a carry-out bit, and an indication of whether the carry flag should change. A zero amount never disturbs the flag.

Amounts from 0 to 255 are all defined. At an amount of exactly one word width the logical shifts hand the last bit shifted out to the carry. Above that width they return zero with a clear carry. The arithmetic shift saturates to a sign fill. The rotate works modulo the word width.

A request is taken when `req_valid` is high on a rising clock edge. The result appears on the registered outputs one cycle later, marked by `rsp_valid`. The block holds its own carry flag register, and that register is visible on `carry_flag`.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits [7:0] of `shift_amt` set the amount. The upper bits of `shift_amt` never change the result, the carry or the update indication.
- R2: An amount of 0 returns `src` unchanged with `carry_upd` low, and the carry flag keeps its previous value. This holds for all four kinds.
- R3: With `kind` = 2'b00 (logical left) and an amount from 1 to 31, the result is `src` shifted left. The carry becomes `src` bit (32 - amount).
- R4: With `kind` = 2'b00, an amount of 32 gives result 0 and a carry equal to `src` bit 0. An amount from 33 to 255 gives result 0 and carry 0.
- R5: With `kind` = 2'b01 (logical right) and an amount from 1 to 31, the result is `src` shifted right with zero fill. The carry becomes `src` bit (amount - 1).
- R6: With `kind` = 2'b01, an amount of 32 gives result 0 and a carry equal to `src` bit 31. An amount from 33 to 255 gives result 0 and carry 0.
- R7: With `kind` = 2'b10 (arithmetic right) and an amount from 1 to 31, the result is `src` shifted right with sign fill. The carry becomes `src` bit (amount - 1).
- R8: With `kind` = 2'b10 and an amount from 32 to 255, every result bit equals `src` bit 31, and the carry equals `src` bit 31.
- R9: With `kind` = 2'b11 (rotate right), let k be the amount modulo 32. When k is non-zero, the result is `src` rotated right by k and the carry is `src` bit (k - 1).
- R10: With `kind` = 2'b11 and a non-zero amount whose low five bits are zero (32, 64, ..., 224), the result is `src` unchanged and the carry becomes `src` bit 31.
- R11: The carry flag register loads the new carry only on an accepted request with a non-zero amount. It holds in every other cycle, and a synchronous reset clears it.
- R12: `rsp_valid` is high exactly one cycle after each accepted request. After reset, `rsp_valid`, `result`, `carry_upd` and `carry_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| src | input | 32 | Operand to shift |
| shift_amt | input | 32 | Register holding the amount; only bits [7:0] are used |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Shifted or rotated operand |
| carry_upd | output | 1 | High when the request changed the carry flag |
| carry_flag | output | 1 | Carry flag register |

## Verification
The bench aims at the amount boundaries: 0, 1, 31, 32, 33, 64, 96 and 255. Together with varied upper bits in the amount register, these points separate the correct design from several plausible faults:
- A shifter that uses the amount modulo 32 for the logical kinds would return the operand unchanged at 32 and 64.
- A design that treats an amount of 32 like a larger one would lose the bit-0 or bit-31 carry.
- Using the full register as the amount would turn small shifts into zero results.
- A zero-amount request that wrote the flag anyway would show up as a flag changing after an operation meant to leave it alone.

The rotate at multiples of 32 is checked for an unchanged value with the carry taken from bit 31, which a plain modulo rotate misses. Reset in the middle of a run and idle cycles between requests expose a flag that is not held or not cleared.

// File: rtl/reg_shift_carry.sv
module reg_shift_carry #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [1:0]   kind,
  input  logic [W-1:0] src,
  input  logic [W-1:0] shift_amt,
  output logic         rsp_valid,
  output logic [W-1:0] result,
  output logic         carry_upd,
  output logic         carry_flag
);
  localparam int SH_W = $clog2(W);

  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;

  logic [AMT_W-1:0] amt;
  logic [SH_W-1:0]  sh;
  logic             amt_zero, amt_word, amt_over;
  logic             unused_hi_bits;

  assign amt            = shift_amt[AMT_W-1:0];
  assign sh             = amt[SH_W-1:0];
  assign amt_zero       = (amt == '0);
  assign amt_word       = (int'(amt) == W);
  assign amt_over       = (int'(amt) > W);
  assign unused_hi_bits = ^shift_amt[W-1:AMT_W];

  logic        [W:0] lsl_w, lsr_w;
  logic signed [W:0] asr_w;
  logic      [W-1:0] ror_r;

  assign lsl_w = {1'b0, src} << sh;
  assign lsr_w = {src, 1'b0} >> sh;
  assign asr_w = $signed({src, 1'b0}) >>> sh;
  assign ror_r = (src >> sh) | (src << (W - int'(sh)));

  logic [W-1:0] nx_res;
  logic         nx_c;

  always_comb begin
    nx_res = src;
    nx_c   = carry_flag;
    if (!amt_zero) begin
      unique case (kind)
        K_LSL: begin
          if (amt_over)      begin nx_res = '0; nx_c = 1'b0;   end
          else if (amt_word) begin nx_res = '0; nx_c = src[0]; end
          else               begin nx_res = lsl_w[W-1:0]; nx_c = lsl_w[W]; end
        end
        K_LSR: begin
          if (amt_over)      begin nx_res = '0; nx_c = 1'b0;     end
          else if (amt_word) begin nx_res = '0; nx_c = src[W-1]; end
          else               begin nx_res = lsr_w[W:1]; nx_c = lsr_w[0]; end
        end
        K_ASR: begin
          if (amt_over || amt_word) begin nx_res = {W{src[W-1]}}; nx_c = src[W-1]; end
          else                      begin nx_res = asr_w[W:1]; nx_c = asr_w[0]; end
        end
        default: begin
          nx_res = ror_r;
          nx_c   = ror_r[W-1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      result     <= '0;
      carry_upd  <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        result    <= nx_res;
        carry_upd <= !amt_zero;
        if (!amt_zero) carry_flag <= nx_c;
      end
    end
  end

  p_zero_keeps_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && shift_amt[AMT_W-1:0] == '0) |=> (carry_flag == $past(carry_flag) && !carry_upd));

  p_zero_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && shift_amt[AMT_W-1:0] == '0) |=> (result == $past(src)));

  p_idle_holds_carry_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(carry_flag));

  p_big_logical_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !kind[1] && int'(shift_amt[AMT_W-1:0]) > W) |=> (result == '0 && !carry_flag));

  p_asr_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_ASR && int'(shift_amt[AMT_W-1:0]) >= W)
    |=> (result == {W{$past(src[W-1])}} && carry_flag == $past(src[W-1])));

  p_ror_word_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_ROR && shift_amt[AMT_W-1:0] != '0 && shift_amt[SH_W-1:0] == '0)
    |=> (result == $past(src) && carry_flag == $past(src[W-1])));

  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/reg_shift_carry_test.sv
module reg_shift_carry_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [31:0] src = '0;
  logic [31:0] shift_amt = '0;
  logic        rsp_valid, carry_upd, carry_flag;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic model_c = 1'b0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  reg_shift_carry uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .kind(kind), .src(src),
    .shift_amt(shift_amt), .rsp_valid(rsp_valid), .result(result),
    .carry_upd(carry_upd), .carry_flag(carry_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [33:0] model(input logic [1:0] k, input int n,
                                        input logic [31:0] x, input logic cin);
    logic [31:0] r;
    logic c;
    int m;
    r = x; c = cin;
    if (n != 0) begin
      case (k)
        2'b00: if (n < 32) begin r = x << n; c = x[32-n]; end
               else if (n == 32) begin r = 0; c = x[0]; end
               else begin r = 0; c = 0; end
        2'b01: if (n < 32) begin r = x >> n; c = x[n-1]; end
               else if (n == 32) begin r = 0; c = x[31]; end
               else begin r = 0; c = 0; end
        2'b10: if (n < 32) begin r = $unsigned($signed(x) >>> n); c = x[n-1]; end
               else begin r = {32{x[31]}}; c = x[31]; end
        default: begin
          m = n % 32;
          if (m == 0) begin r = x; c = x[31]; end
          else begin r = (x >> m) | (x << (32 - m)); c = x[m-1]; end
        end
      endcase
    end
    return {(n != 0), c, r};
  endfunction

  function automatic string req_tag(input logic [1:0] k, input int n);
    if (n == 0) return "R2";
    case (k)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return (n < 32) ? "R5" : "R6";
      2'b10: return (n < 32) ? "R7" : "R8";
      default: return (n % 32 != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [31:0] amtreg,
                       input logic [31:0] x, input string tag);
    logic [33:0] e;
    @(negedge clk);
    e = model(k, int'(amtreg[7:0]), x, model_c);
    model_c = e[32];
    exp_q.push_back(e);
    tag_q.push_back(tag == "" ? req_tag(k, int'(amtreg[7:0])) : tag);
    req_valid = 1'b1; kind = k; shift_amt = amtreg; src = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      shift_amt = 32'hFFFF_FF00 ^ 32'(i); src = 32'h1234_5678;
    end
  endtask

  // monitor: pop expected items as responses appear (R12 timing)
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R12", 32'(rsp_valid), 32'd0);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, result, e[31:0]);
        check(t, 32'(carry_flag), 32'(e[32]));
        check(t, 32'(carry_upd), 32'(e[33]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats[4];
    int amts[11];
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'hFFFF_FFFF};
    amts = '{0, 1, 5, 16, 31, 32, 33, 64, 96, 200, 255};
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", 32'(rsp_valid), 0);
    check("R12", result, 0);
    check("R12", 32'(carry_upd), 0);
    check("R12", 32'(carry_flag), 0);
    rst = 1'b0;

    // R3..R10 and R2 across all kinds, amounts and patterns
    foreach (pats[p])
      for (int k = 0; k < 4; k++)
        foreach (amts[a]) drive(2'(k), 32'(amts[a]), pats[p], "");
    idle(2);

    // R1: upper amount bits are ignored
    drive(2'b00, 32'hDEAD_BE04, 32'h0F00_0001, "R1");
    drive(2'b01, 32'h0000_0100, 32'h8000_0001, "R1");
    drive(2'b11, 32'hFFFF_FF21, 32'h0000_0003, "R1");
    drive(2'b10, 32'h1234_5620, 32'h8000_0000, "R1");
    idle(2);

    // R11: set carry, then idle cycles and zero amounts must hold it
    drive(2'b01, 32'd1, 32'h0000_0001, "R11");
    idle(4);
    check("R11", 32'(carry_flag), 32'(model_c));
    drive(2'b11, 32'h0000_0000, 32'h0000_0000, "R11");
    drive(2'b00, 32'hFFFF_FF00, 32'hFFFF_FFFF, "R11");
    idle(3);
    check("R11", 32'(carry_flag), 32'(model_c));

    // R11: synchronous reset clears the carry
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11", 32'(carry_flag), 0);
    check("R12", 32'(rsp_valid), 0);
    rst = 1'b0;
    model_c = 1'b0;
    drive(2'b00, 32'd0, 32'hCAFE_F00D, "R2");
    drive(2'b10, 32'd40, 32'h8000_0000, "R8");
    idle(3);
    check("R12", 32'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule